// File: doc/BRIEF.md
# Serial EEPROM Burst Read Sequencer

This block is the host side of a three-wire serial EEPROM link, used only for reading. Software or a boot engine gives it a first word address, a number of words and a one-cycle start pulse. The block then produces the chip select, serial clock and serial data-out waveforms for each word in turn and samples the device's data line. Every recovered 16-bit word appears on `word_data` together with a one-cycle `word_valid` strobe. A one-cycle `done` pulse marks the end of the burst.

Each word is a separate transaction. The block raises chip select and holds it for one serial clock period with data-out low. It then shifts out a start bit, the read opcode and the word address. After that it clocks in seventeen bits. The first of these is a dummy zero and is lost, and the other sixteen form the word. Chip select then drops for one full serial clock cycle before the next word begins. The serial clock comes from the system clock. `LOW_CYC` and `HIGH_CYC` set the length of each phase in system cycles, so the device's minimum high time, low time and select setup time can be met at any system frequency.

The controller has six states:
- `ST_IDLE` goes to `ST_SELECT` on start when the count is non-zero. With a zero count it stays in `ST_IDLE` and pulses done.
- `ST_SELECT` goes to `ST_COMMAND` after one slot.
- `ST_COMMAND` goes to `ST_ADDRESS` after three slots.
- `ST_ADDRESS` goes to `ST_READ` after `ADDR_W` slots.
- `ST_READ` goes to `ST_DESELECT` after seventeen slots.
- `ST_DESELECT` returns to `ST_SELECT` while words remain, and otherwise goes to `ST_IDLE` and pulses done.

Top module: `eeprom_burst_reader`

## Requirements
- R1: After reset `ee_cs`, `ee_sclk`, `ee_mosi`, `word_valid` and `done` are all low.
- R2: During a burst every serial clock high phase lasts exactly `HIGH_CYC` system cycles and every low phase lasts exactly `LOW_CYC`. `ee_cs` and `ee_mosi` change only while `ee_sclk` is low.
- R3: Each word starts with a select slot. `ee_cs` rises and exactly one serial clock cycle is driven with `ee_mosi` low before the start bit.
- R4: After the select slot the three bits 1, 1, 0 are shifted out: a start bit of 1, then the read opcode 2'b10, MSB first.
- R5: The word address follows as `ADDR_W` bits, MSB first. Each bit is held through its whole slot.
- R6: Seventeen bits are sampled from `ee_miso`, each on the system clock edge at which `ee_sclk` rises. The first bit is discarded. The remaining sixteen form `word_data`, first bit in bit 15.
- R7: Each word is reported by a `word_valid` pulse exactly one cycle long. `word_data` holds that word until the next pulse, and exactly `word_count` pulses occur per burst.
- R8: After each word `ee_cs` drops and exactly one full serial clock cycle (low, high, low) is driven with `ee_cs` low. Only then does the next select slot start.
- R9: Word i of a burst is read from address `start_addr + i` modulo 2^`ADDR_W`, and results are reported in that order.
- R10: `done` pulses high for one cycle right after the final deselect slot and never otherwise during a burst.
- R11: A start with `word_count` equal to zero gives `done` in the following cycle, with no serial clock edge and no chip select.
- R12: A start pulse that arrives while a burst is in progress is ignored. The running burst keeps its addresses and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a burst while idle |
| start_addr | input | ADDR_W | Address of the first word |
| word_count | input | ADDR_W+1 | Number of words to read |
| ee_sclk | output | 1 | Serial clock to the device |
| ee_cs | output | 1 | Chip select to the device, active high |
| ee_mosi | output | 1 | Serial data to the device's input |
| ee_miso | input | 1 | Serial data from the device's output |
| word_valid | output | 1 | One-cycle strobe for each recovered word |
| word_data | output | 16 | Recovered word, held until the next strobe |
| done | output | 1 | One-cycle pulse at the end of a burst |

## Verification
The bench contains a behavioural device model. It skips leading zeros until it sees a start bit, records the opcode and address of each command, and drives the dummy zero and then the word on the rising serial edges. A design that failed to drop the dummy bit would return every word shifted right by one bit, and the data checks would catch this. A design with an extra or a missing select or deselect cycle would show the wrong leading-zero count or the wrong number of serial rises with chip select low. Further tests cover a burst that wraps past the top address, a zero count, which must finish at once without a serial edge, and a second start in the middle of a burst, which must not change the address sequence or the word total. A monitor measures the width of every serial phase and flags any change of chip select or data-out while the clock is high.

// File: rtl/eeb_pkg.sv
package eeb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_COMMAND,
        ST_ADDRESS,
        ST_READ,
        ST_DESELECT
    } eeb_state_e;

    localparam int unsigned EEB_WORD_W    = 16;
    localparam int unsigned EEB_READ_BITS = EEB_WORD_W + 1;
    localparam int unsigned EEB_CMD_BITS  = 3;
    // start bit, then read opcode; sent from bit 2 down to bit 0
    localparam logic [EEB_CMD_BITS-1:0] EEB_READ_CMD = 3'b110;

endpackage

// File: rtl/eeb_phase_timer.sv
module eeb_phase_timer #(
    parameter int unsigned LOW_CYC  = 50,
    parameter int unsigned HIGH_CYC = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise_evt,
    output logic slot_end
);

    localparam int unsigned MAX_CYC = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt;
    logic             phase_hi;

    assign sclk     = phase_hi;
    assign rise_evt = run && !phase_hi && (cnt == CNT_W'(LOW_CYC - 1));
    assign slot_end = run &&  phase_hi && (cnt == CNT_W'(HIGH_CYC - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt      <= '0;
            phase_hi <= 1'b0;
        end else if (rise_evt) begin
            cnt      <= '0;
            phase_hi <= 1'b1;
        end else if (slot_end) begin
            cnt      <= '0;
            phase_hi <= 1'b0;
        end else begin
            cnt      <= cnt + CNT_W'(1);
        end
    end

    // R2: a phase never outlasts its programmed length
    assert_low_phase_bounded_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        (run && !phase_hi) |-> (cnt < CNT_W'(LOW_CYC)));
    assert_high_phase_bounded_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        (run && phase_hi) |-> (cnt < CNT_W'(HIGH_CYC)));

endmodule

// File: rtl/eeb_word_shifter.sv
module eeb_word_shifter #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              bit_in,
    input  logic              publish,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid
);

    // Seventeen shifts into a sixteen-bit register push the dummy bit out the top
    logic [WORD_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg      <= '0;
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            if (capture) begin
                shreg <= {shreg[WORD_W-2:0], bit_in};
            end
            word_valid <= publish;
            if (publish) begin
                word_out <= shreg;
            end
        end
    end

    // R7: each word strobe lasts one cycle
    assert_valid_single_cycle_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R7: data is held between strobes
    assert_word_held_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> $stable(word_out));

endmodule

// File: rtl/eeprom_burst_reader.sv
module eeprom_burst_reader
    import eeb_pkg::*;
#(
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned LOW_CYC  = 50,
    parameter int unsigned HIGH_CYC = 150,
    localparam int unsigned CNT_W   = ADDR_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [ADDR_W-1:0]     start_addr,
    input  logic [CNT_W-1:0]      word_count,
    output logic                  ee_sclk,
    output logic                  ee_cs,
    output logic                  ee_mosi,
    input  logic                  ee_miso,
    output logic                  word_valid,
    output logic [EEB_WORD_W-1:0] word_data,
    output logic                  done
);

    localparam int unsigned IDX_W = 5;
    localparam int unsigned AIW   = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;

    eeb_state_e         state, state_nx;
    logic [IDX_W-1:0]   idx, idx_nx;
    logic [ADDR_W-1:0]  cur_addr, addr_nx;
    logic [CNT_W-1:0]   remaining, rem_nx;
    logic               done_nx;

    logic               run;
    logic               rise_evt;
    logic               slot_end;
    logic               capture;
    logic               publish;
    logic [1:0]         cmd_sel;

    eeb_phase_timer #(
        .LOW_CYC  (LOW_CYC),
        .HIGH_CYC (HIGH_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .sclk     (ee_sclk),
        .rise_evt (rise_evt),
        .slot_end (slot_end)
    );

    assign capture = (state == ST_READ) && rise_evt;
    assign publish = (state == ST_READ) && slot_end
                     && (idx == IDX_W'(EEB_READ_BITS - 1));

    eeb_word_shifter #(
        .WORD_W (EEB_WORD_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .bit_in     (ee_miso),
        .publish    (publish),
        .word_out   (word_data),
        .word_valid (word_valid)
    );

    // next-state and counter logic
    always_comb begin
        state_nx = state;
        idx_nx   = idx;
        addr_nx  = cur_addr;
        rem_nx   = remaining;
        done_nx  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (word_count == '0) begin
                        done_nx = 1'b1;
                    end else begin
                        state_nx = ST_SELECT;
                        addr_nx  = start_addr;
                        rem_nx   = word_count;
                        idx_nx   = '0;
                    end
                end
            end
            ST_SELECT: begin
                if (slot_end) begin
                    state_nx = ST_COMMAND;
                    idx_nx   = '0;
                end
            end
            ST_COMMAND: begin
                if (slot_end) begin
                    if (idx == IDX_W'(EEB_CMD_BITS - 1)) begin
                        state_nx = ST_ADDRESS;
                        idx_nx   = IDX_W'(ADDR_W - 1);
                    end else begin
                        idx_nx = idx + IDX_W'(1);
                    end
                end
            end
            ST_ADDRESS: begin
                if (slot_end) begin
                    if (idx == '0) begin
                        state_nx = ST_READ;
                    end else begin
                        idx_nx = idx - IDX_W'(1);
                    end
                end
            end
            ST_READ: begin
                if (slot_end) begin
                    if (idx == IDX_W'(EEB_READ_BITS - 1)) begin
                        state_nx = ST_DESELECT;
                        idx_nx   = '0;
                    end else begin
                        idx_nx = idx + IDX_W'(1);
                    end
                end
            end
            ST_DESELECT: begin
                if (slot_end) begin
                    rem_nx  = remaining - CNT_W'(1);
                    addr_nx = cur_addr + ADDR_W'(1);
                    if (remaining == CNT_W'(1)) begin
                        state_nx = ST_IDLE;
                        done_nx  = 1'b1;
                    end else begin
                        state_nx = ST_SELECT;
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            idx       <= '0;
            cur_addr  <= '0;
            remaining <= '0;
            done      <= 1'b0;
        end else begin
            state     <= state_nx;
            idx       <= idx_nx;
            cur_addr  <= addr_nx;
            remaining <= rem_nx;
            done      <= done_nx;
        end
    end

    // outputs decoded from the registered state
    always_comb begin
        cmd_sel = 2'd2 - idx[1:0];
        run     = (state != ST_IDLE);
        ee_cs   = 1'b0;
        ee_mosi = 1'b0;
        unique case (state)
            ST_IDLE:     ee_cs = 1'b0;
            ST_SELECT:   ee_cs = 1'b1;
            ST_COMMAND: begin
                ee_cs   = 1'b1;
                ee_mosi = EEB_READ_CMD[cmd_sel];
            end
            ST_ADDRESS: begin
                ee_cs   = 1'b1;
                ee_mosi = cur_addr[idx[AIW-1:0]];
            end
            ST_READ:     ee_cs = 1'b1;
            ST_DESELECT: ee_cs = 1'b0;
            default:     ee_cs = 1'b0;
        endcase
    end

    // R2: chip select moves only in a low phase
    assert_cs_moves_low_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ee_cs) |-> !ee_sclk);

    // R5: data-out moves only in a low phase
    assert_mosi_moves_low_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ee_mosi) |-> !ee_sclk);

    // R8: deselect slot always drives chip select low
    assert_deselect_cs_low_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_READ && state == ST_DESELECT) |-> (!ee_cs && !ee_sclk));

    // R10: the final deselect is followed by done
    assert_done_after_deselect_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_DESELECT && state == ST_IDLE) |-> done);

    // R11: zero count finishes at once, serial clock idle
    assert_zero_count_done_R11 : assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && word_count == '0) |=> (done && !ee_sclk && !ee_cs));

    // R12: a start during a burst leaves address and count untouched
    assert_busy_start_ignored_R12 : assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && start && !slot_end) |=> ($stable(cur_addr) && $stable(remaining)));

endmodule

// File: tb/test_eeprom_burst_reader.sv
`timescale 1ns/1ps
module test_eeprom_burst_reader;

    localparam int AW  = 6;
    localparam int CW  = AW + 1;
    localparam int LOW = 2;
    localparam int HIGH = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [CW-1:0] word_count = '0;
    logic          ee_sclk, ee_cs, ee_mosi;
    logic          ee_miso = 1'b0;
    logic          word_valid, done;
    logic [15:0]   word_data;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;

    eeprom_burst_reader #(
        .ADDR_W   (AW),
        .LOW_CYC  (LOW),
        .HIGH_CYC (HIGH)
    ) i_eeprom_burst_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .word_count (word_count),
        .ee_sclk    (ee_sclk),
        .ee_cs      (ee_cs),
        .ee_mosi    (ee_mosi),
        .ee_miso    (ee_miso),
        .word_valid (word_valid),
        .word_data  (word_data),
        .done       (done)
    );

    function automatic logic [15:0] mem_word(input logic [AW-1:0] a);
        return 16'hB4E1 ^ {a, 4'h9, ~a};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- device model ----------------
    int            m_lead, m_rx, m_pos, m_cmds, des_rises, sclk_rises;
    bit            m_started;
    logic [AW+1:0] m_hdr;
    logic [AW-1:0] m_addr;
    int            cmd_addr [64];
    int            cmd_op   [64];
    int            cmd_lead [64];

    always @(posedge ee_cs) begin
        m_started = 1'b0;
        m_lead    = 0;
        m_rx      = 0;
        m_pos     = -1;
    end

    always @(posedge ee_sclk) begin
        sclk_rises++;
        if (!ee_cs) begin
            des_rises++;
        end else if (m_pos >= 0) begin
            m_pos++;
            if (m_pos <= 16) ee_miso <= mem_word(m_addr)[16 - m_pos];
            else             ee_miso <= 1'b0;
        end else if (!m_started) begin
            if (ee_mosi) m_started = 1'b1;
            else         m_lead++;
        end else begin
            m_hdr = {m_hdr[AW:0], ee_mosi};
            m_rx++;
            if (m_rx == AW + 2) begin
                m_addr = m_hdr[AW-1:0];
                if (m_cmds < 64) begin
                    cmd_addr[m_cmds] = int'(m_hdr[AW-1:0]);
                    cmd_op[m_cmds]   = int'(m_hdr[AW+1:AW]);
                    cmd_lead[m_cmds] = m_lead;
                end
                m_cmds++;
                ee_miso <= 1'b0;
                m_pos = 0;
            end
        end
    end

    // ---------------- output monitor ----------------
    int          n_words, n_done, valid_runs, phase_bad, hold_bad;
    logic [15:0] got [64];
    bit          in_burst, seen_fall, prev_sclk, prev_cs, prev_mosi, prev_valid;
    int          hi_len, lo_len;

    always @(negedge clk) begin
        if (rst_n) begin
            if (word_valid) begin
                if (n_words < 64) got[n_words] = word_data;
                n_words++;
                if (prev_valid) valid_runs++;
            end
            if (done) n_done++;
            if (ee_sclk && prev_sclk && (ee_cs != prev_cs || ee_mosi != prev_mosi)) hold_bad++;
            if (ee_sclk) begin
                if (!prev_sclk) begin
                    if (in_burst && seen_fall && lo_len != LOW) phase_bad++;
                    hi_len = 0;
                end
                hi_len++;
            end else begin
                if (prev_sclk) begin
                    if (hi_len != HIGH) phase_bad++;
                    seen_fall = 1'b1;
                    lo_len = 0;
                end
                lo_len++;
            end
        end
        prev_sclk  = ee_sclk;
        prev_cs    = ee_cs;
        prev_mosi  = ee_mosi;
        prev_valid = word_valid;
    end

    task automatic clear_records();
        n_words = 0; n_done = 0; valid_runs = 0; phase_bad = 0; hold_bad = 0;
        m_cmds = 0; des_rises = 0; seen_fall = 1'b0;
    endtask

    task automatic pulse_start(input logic [AW-1:0] a, input logic [CW-1:0] c);
        @(negedge clk);
        start_addr = a;
        word_count = c;
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic verify_burst(input logic [AW-1:0] a, input int c);
        check(n_words == c, "R7 word count", n_words, c);
        check(valid_runs == 0, "R7 valid single cycle", valid_runs, 0);
        check(m_cmds == c, "R9 command count", m_cmds, c);
        for (int i = 0; i < c && i < 64; i++) begin
            logic [AW-1:0] ea;
            ea = a + AW'(i);
            check(got[i] == mem_word(ea), "R6 word data", int'(got[i]), int'(mem_word(ea)));
            check(cmd_addr[i] == int'(ea), "R9 R5 address", cmd_addr[i], int'(ea));
            check(cmd_op[i] == 2, "R4 read opcode", cmd_op[i], 2);
            check(cmd_lead[i] == 1, "R3 select slot", cmd_lead[i], 1);
        end
        check(des_rises == c, "R8 deselect cycles", des_rises, c);
        check(n_done == 1, "R10 done pulse", n_done, 1);
        check(phase_bad == 0, "R2 phase widths", phase_bad, 0);
        check(hold_bad == 0, "R2 R5 stable while high", hold_bad, 0);
        check(!ee_cs && !ee_sclk, "R8 idle after burst", {ee_cs, ee_sclk}, 0);
    endtask

    task automatic t_burst(input logic [AW-1:0] a, input int c);
        clear_records();
        in_burst = 1'b1;
        pulse_start(a, CW'(c));
        wait_done();
        in_burst = 1'b0;
        verify_burst(a, c);
    endtask

    task automatic t_reset();
        check(!ee_cs && !ee_sclk && !ee_mosi, "R1 serial pins idle", {ee_cs, ee_sclk, ee_mosi}, 0);
        check(!word_valid && !done, "R1 strobes low", {word_valid, done}, 0);
    endtask

    task automatic t_zero_count();
        int rises_before;
        clear_records();
        rises_before = sclk_rises;
        @(negedge clk);
        start_addr = 6'd9;
        word_count = '0;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1, "R11 done next cycle", done, 1);
        check(!ee_cs, "R11 no chip select", ee_cs, 0);
        repeat (20) @(negedge clk);
        check(sclk_rises == rises_before, "R11 no serial clock", sclk_rises, rises_before);
        check(n_done == 1 && n_words == 0, "R11 single done", n_done, 1);
    endtask

    task automatic t_busy_ignore();
        clear_records();
        in_burst = 1'b1;
        pulse_start(6'd10, CW'(2));
        repeat (40) @(negedge clk);
        start_addr = 6'd40;
        word_count = CW'(5);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        in_burst = 1'b0;
        check(n_words == 2, "R12 busy start ignored words", n_words, 2);
        verify_burst(6'd10, 2);
    endtask

    initial begin
        clear_records();
        sclk_rises = 0;
        in_burst = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_burst(6'd5, 4);
        t_burst(6'd0, 1);
        t_burst(6'd62, 3);   // wraps to address 0
        t_zero_count();
        t_busy_ignore();
        t_burst(6'd33, 2);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule